// File: doc/BRIEF.md
# Gated Pulse Train Generator

This block produces a repeating pulse train from a timebase. A source-tick enable marks the clock cycles that count as timebase ticks. Each output period has two phases. The inactive phase comes first and lasts a programmable number of ticks. The active phase comes second and lasts its own programmable number of ticks. Because the inactive phase comes first, the first active edge after enable arrives one full inactive phase later. A gate input qualifies the train, and a mode select chooses how the gate acts on it. The output can be inverted. The gate is typically the pulse of an external one-shot that defines an acquisition window, and the train paces events inside that window.

A state machine with three states drives the counter. `ST_LOAD` is entered on reset and left after one clock for `ST_DELAY`; it captures the count inputs. `ST_DELAY` counts the inactive phase and moves to `ST_PULSE` on its last tick. `ST_PULSE` counts the active phase; on its last tick it returns to `ST_DELAY` and captures the count inputs again. When no tick qualifies, the state machine takes no transition. An output stage then applies the selected gating and the polarity.

Top module: `gated_pulse_gen`

## Requirements
- R1: Each period is `delay_ticks` qualified ticks at the inactive level followed by `pulse_ticks` qualified ticks at the active level. A clock cycle with `src_tick` low advances nothing.
- R2: A delay count below 2 is used as 2, and a pulse count of 0 is used as 1.
- R3: The count inputs are captured only at a period boundary, meaning in `ST_LOAD` or at the end of `ST_PULSE`. A change made during a period takes effect in the next period.
- R4: While reset is asserted and in the first cycle after it, the machine is in `ST_LOAD` and `pulse_out` equals `invert`.
- R5: `pulse_out` is the active signal XOR `invert`. With `invert`=1 the idle level is therefore high.
- R6: `gate_in` is used only after two flops clocked by `clk`. A gate edge first affects the logic two clock edges after it is set up.
- R7: With `gate_mode`=0, and also with the unused code 3, the counter runs freely and the active signal is the counter phase ANDed with the synchronised gate.
- R8: With `gate_mode`=1, the counter runs freely. The AND of the counter phase with the gate is taken only when the counter phase changes, and it is held until the next change.
- R9: With `gate_mode`=2, ticks count only while the synchronised gate is high, and the counter phase drives the output directly. With the gate held low from the start of a delay, raising the gate gives the first active edge `delay_ticks`+2 clocks later (ticks every cycle). Moving 2 counts from delay to pulse therefore moves that edge 2 clocks earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 1 | Timebase tick enable, one tick per high cycle |
| gate_in | input | 1 | Asynchronous gate |
| delay_ticks | input | 16 | Inactive-phase length in ticks |
| pulse_ticks | input | 16 | Active-phase length in ticks |
| gate_mode | input | 2 | 0 output AND, 1 latched AND, 2 frozen source, 3 as 0 |
| invert | input | 1 | Output polarity inversion |
| pulse_out | output | 1 | Pulse train |

## Verification
`pulse_out` is a combinational function of registers, `gate_mode` and `invert`. A change to `invert` therefore shows at once, while a state change shows after the clock edge that makes it. A raised gate reaches the logic after two edges, and in frozen mode the first active edge comes `delay_ticks`+2 edges after the gate is set. The bench drives and samples only at falling edges, and it counts the edges from a stimulus up to the sampled level change. A bench reference model advances its own state on every rising edge, and the bench compares `pulse_out` with that model at every falling edge during the random runs.

// File: rtl/gpg_pkg.sv
package gpg_pkg;
    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_DELAY = 2'd1,
        ST_PULSE = 2'd2
    } state_t;

    typedef enum logic [1:0] {
        GM_AND    = 2'd0,
        GM_LATCH  = 2'd1,
        GM_FREEZE = 2'd2,
        GM_SPARE  = 2'd3
    } gmode_t;
endpackage

// File: rtl/gpg_sync.sv
module gpg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       chain_q[i] <= 1'b0;
                else if (i == 0)  chain_q[i] <= d;
                else              chain_q[i] <= chain_q[(i > 0) ? i - 1 : 0];
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpg_phase_fsm.sv
module gpg_phase_fsm
    import gpg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [CNT_W-1:0] delay_ticks,
    input  logic [CNT_W-1:0] pulse_ticks,
    output state_t           st,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] dly_q,
    output logic [CNT_W-1:0] pw_q,
    output logic             phase_hi
);
    localparam logic [CNT_W-1:0] MIN_DLY = CNT_W'(2);
    localparam logic [CNT_W-1:0] MIN_PW  = CNT_W'(1);

    state_t           st_d;
    logic [CNT_W-1:0] cnt_d, dly_d, pw_d, dly_cl, pw_cl;

    always_comb begin
        dly_cl = (delay_ticks < MIN_DLY) ? MIN_DLY : delay_ticks;
        pw_cl  = (pulse_ticks < MIN_PW)  ? MIN_PW  : pulse_ticks;
    end

    // next-state process
    always_comb begin
        st_d  = st;
        cnt_d = cnt;
        dly_d = dly_q;
        pw_d  = pw_q;
        unique case (st)
            ST_LOAD: begin
                st_d  = ST_DELAY;
                cnt_d = '0;
                dly_d = dly_cl;
                pw_d  = pw_cl;
            end
            ST_DELAY: begin
                if (advance) begin
                    if (cnt == dly_q - 1'b1) begin
                        st_d  = ST_PULSE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt + 1'b1;
                    end
                end
            end
            ST_PULSE: begin
                if (advance) begin
                    if (cnt == pw_q - 1'b1) begin
                        st_d  = ST_DELAY;
                        cnt_d = '0;
                        dly_d = dly_cl;
                        pw_d  = pw_cl;
                    end else begin
                        cnt_d = cnt + 1'b1;
                    end
                end
            end
            default: st_d = ST_LOAD;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_LOAD;
            cnt   <= '0;
            dly_q <= MIN_DLY;
            pw_q  <= MIN_PW;
        end else begin
            st    <= st_d;
            cnt   <= cnt_d;
            dly_q <= dly_d;
            pw_q  <= pw_d;
        end
    end

    // output process
    always_comb begin
        phase_hi = (st == ST_PULSE);
    end
endmodule

// File: rtl/gpg_out_stage.sv
module gpg_out_stage
    import gpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] gate_mode,
    input  logic       invert,
    input  logic       phase_hi,
    input  logic       gate_s,
    output logic       pulse_out
);
    logic phase_prev_q, hold_q, hold_now, active;

    always_comb begin
        hold_now = (phase_hi != phase_prev_q) ? (phase_hi & gate_s) : hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_prev_q <= 1'b0;
            hold_q       <= 1'b0;
        end else begin
            phase_prev_q <= phase_hi;
            hold_q       <= hold_now;
        end
    end

    always_comb begin
        unique case (gmode_t'(gate_mode))
            GM_LATCH:  active = hold_now;
            GM_FREEZE: active = phase_hi;
            default:   active = phase_hi & gate_s;
        endcase
        pulse_out = active ^ invert;
    end
endmodule

// File: rtl/gated_pulse_gen.sv
module gated_pulse_gen
    import gpg_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  logic             gate_in,
    input  logic [CNT_W-1:0] delay_ticks,
    input  logic [CNT_W-1:0] pulse_ticks,
    input  logic [1:0]       gate_mode,
    input  logic             invert,
    output logic             pulse_out
);
    logic             gate_s, advance, phase_hi;
    state_t           st;
    logic [CNT_W-1:0] cnt, dly_q, pw_q;

    gpg_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(gate_in), .q(gate_s)
    );

    always_comb begin
        advance = src_tick & ((gmode_t'(gate_mode) != GM_FREEZE) | gate_s);
    end

    gpg_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .advance(advance),
        .delay_ticks(delay_ticks), .pulse_ticks(pulse_ticks),
        .st(st), .cnt(cnt), .dly_q(dly_q), .pw_q(pw_q), .phase_hi(phase_hi)
    );

    gpg_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .gate_mode(gate_mode), .invert(invert),
        .phase_hi(phase_hi), .gate_s(gate_s), .pulse_out(pulse_out)
    );
endmodule

// File: rtl/gpg_checker.sv
module gpg_checker
    import gpg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       gate_mode,
    input logic             invert,
    input logic             gate_s,
    input logic             advance,
    input state_t           st,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] dly,
    input logic [CNT_W-1:0] pw,
    input logic             pulse_out
);
    a_r1_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_LOAD && !advance) |=> ($stable(cnt) && $stable(st)));

    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DELAY) |-> (cnt < dly));

    a_r1_pw_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PULSE) |-> (cnt < pw));

    a_r2_min_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_LOAD) |-> (dly >= CNT_W'(2) && pw >= CNT_W'(1)));

    a_r3_no_reload_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DELAY) |=> ($stable(dly) && $stable(pw)));

    a_r4_reset_level: assert property (@(posedge clk)
        (!rst_n) |-> (pulse_out == invert));

    a_r7_and_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_mode == 2'd0 && !gate_s) |-> (pulse_out == invert));

    a_r9_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_mode == 2'd2 && !gate_s && st != ST_LOAD) |=> ($stable(cnt) && $stable(st)));
endmodule

bind gated_pulse_gen gpg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .gate_mode(gate_mode), .invert(invert),
    .gate_s(gate_s), .advance(advance), .st(st), .cnt(cnt),
    .dly(dly_q), .pw(pw_q), .pulse_out(pulse_out)
);

// File: tb/gated_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module gated_pulse_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_tick = 1'b1;
    logic        gate_in = 1'b0;
    logic [15:0] delay_ticks = 16'd4;
    logic [15:0] pulse_ticks = 16'd2;
    logic [1:0]  gate_mode = 2'd0;
    logic        invert = 1'b0;
    logic        pulse_out;

    int n_run = 0, n_fail = 0;
    bit cmp_en = 1'b0, done = 1'b0;
    int seg_err = 0;

    always #2 clk = ~clk;

    gated_pulse_gen dut_i (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .gate_in(gate_in),
        .delay_ticks(delay_ticks), .pulse_ticks(pulse_ticks),
        .gate_mode(gate_mode), .invert(invert), .pulse_out(pulse_out)
    );

    // reference model, built from the requirements
    logic        m_s1, m_s2, m_prev, m_hold;
    int          m_ph, m_cnt, m_dly, m_pw;

    function automatic int cl_dly(input int v); return (v < 2) ? 2 : v; endfunction
    function automatic int cl_pw(input int v);  return (v < 1) ? 1 : v; endfunction

    function automatic logic model_out();
        logic ph, hn, act;
        ph = (m_ph == 2);
        hn = (ph != m_prev) ? (ph & m_s2) : m_hold;
        case (gate_mode)
            2'd1:    act = hn;
            2'd2:    act = ph;
            default: act = ph & m_s2;
        endcase
        return act ^ invert;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_hold <= 0;
            m_ph <= 0; m_cnt <= 0; m_dly <= 2; m_pw <= 1;
        end else begin
            logic adv, ph;
            adv = src_tick && (gate_mode != 2'd2 || m_s2);
            ph  = (m_ph == 2);
            m_s1 <= gate_in; m_s2 <= m_s1;
            m_prev <= ph;
            m_hold <= (ph != m_prev) ? (ph & m_s2) : m_hold;
            if (m_ph == 0) begin
                m_ph <= 1; m_cnt <= 0;
                m_dly <= cl_dly(delay_ticks); m_pw <= cl_pw(pulse_ticks);
            end else if (adv) begin
                if (m_ph == 1) begin
                    if (m_cnt + 1 >= m_dly) begin m_ph <= 2; m_cnt <= 0; end
                    else m_cnt <= m_cnt + 1;
                end else begin
                    if (m_cnt + 1 >= m_pw) begin
                        m_ph <= 1; m_cnt <= 0;
                        m_dly <= cl_dly(delay_ticks); m_pw <= cl_pw(pulse_ticks);
                    end else m_cnt <= m_cnt + 1;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (cmp_en && pulse_out !== model_out()) begin
                if (seg_err == 0)
                    $display("FAIL R1/R7/R8/R9 random model actual=%0b expected=%0b mode=%0d",
                             pulse_out, model_out(), gate_mode);
                seg_err++;
            end
        end
    endtask

    task automatic until_level(input logic lvl, output int k);
        k = 0;
        do begin step(1); k++; end while (pulse_out !== lvl && k < 5000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int k, k1;
        // R4 / R5: reset level follows polarity
        @(negedge clk);
        check("R4 reset level inv0", pulse_out, 0);
        invert = 1'b1;
        #0.1 check("R4 R5 reset level inv1", pulse_out, 1);
        invert = 1'b0;

        // R9 / R6: frozen source, first edge delay+2 after gate
        gate_mode = 2'd2; gate_in = 0; delay_ticks = 5; pulse_ticks = 3;
        do_reset(); step(10);
        check("R9 frozen idle while gate low", pulse_out, 0);
        gate_in = 1; until_level(1, k1);
        check("R9 R6 first edge delay 5", k1, 7);
        gate_in = 0; delay_ticks = 3; pulse_ticks = 5;
        do_reset(); step(10);
        gate_in = 1; until_level(1, k);
        check("R9 first edge delay 3", k, 5);
        check("R9 edge moves by 2", k1 - k, 2);
        until_level(0, k);
        check("R1 pulse phase length", k, 5);
        until_level(1, k);
        check("R1 delay phase length", k, 3);

        // R2: clamps
        gate_mode = 2'd0; gate_in = 1; delay_ticks = 0; pulse_ticks = 0;
        do_reset(); until_level(1, k);
        check("R2 clamped delay first edge", k, 3);
        until_level(0, k);
        check("R2 clamped pulse", k, 1);
        until_level(1, k);
        check("R2 clamped delay", k, 2);

        // R3: counts taken at period boundary only
        delay_ticks = 4; pulse_ticks = 2;
        do_reset(); step(2);
        delay_ticks = 9; pulse_ticks = 6;
        until_level(1, k);
        check("R3 current delay kept", k, 3);
        until_level(0, k);
        check("R3 current pulse kept", k, 2);
        until_level(1, k);
        check("R3 new delay used", k, 9);
        until_level(0, k);
        check("R3 new pulse used", k, 6);

        // R1: no tick, no progress
        src_tick = 0; delay_ticks = 2; pulse_ticks = 2;
        do_reset(); step(20);
        check("R1 no tick stays inactive", pulse_out, 0);
        src_tick = 1; until_level(1, k);
        check("R1 resumes after ticks", k, 2);

        // R8: latched mode holds across gate drop
        gate_mode = 2'd1; gate_in = 1; delay_ticks = 3; pulse_ticks = 8;
        do_reset(); until_level(1, k);
        check("R8 latched first edge", k, 4);
        step(2); gate_in = 0; step(4);
        check("R8 held after gate drop", pulse_out, 1);
        step(12);
        check("R8 next pulse masked", pulse_out, 0);

        // R7: AND mode drops at once
        gate_mode = 2'd0; gate_in = 1;
        do_reset(); until_level(1, k);
        step(2); gate_in = 0; step(4);
        check("R7 masked after gate drop", pulse_out, 0);

        // R5: inverted idle high
        invert = 1; gate_in = 0;
        do_reset(); step(20);
        check("R5 inverted idle high", pulse_out, 1);
        invert = 0;

        // constrained random against the model
        void'($urandom(32'h5eed_1234));
        for (int seg = 0; seg < 10; seg++) begin
            gate_mode   = 2'($urandom_range(0, 3));
            invert      = 1'($urandom_range(0, 1));
            delay_ticks = 16'($urandom_range(0, 7));
            pulse_ticks = 16'($urandom_range(0, 5));
            gate_in     = 1'($urandom_range(0, 1));
            seg_err = 0;
            do_reset();
            cmp_en = 1;
            for (int c = 0; c < 1500; c++) begin
                src_tick = ($urandom_range(0, 3) != 0);
                if ($urandom_range(0, 15) == 0) gate_in = ~gate_in;
                if ($urandom_range(0, 63) == 0) delay_ticks = 16'($urandom_range(0, 7));
                if ($urandom_range(0, 63) == 0) pulse_ticks = 16'($urandom_range(0, 5));
                step(1);
            end
            cmp_en = 0;
            check("R1 R3 R7 R8 R9 random segment mismatches", seg_err, 0);
        end
        src_tick = 1;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule